// File: doc/BRIEF.md
# Serial EEPROM Bulk-Fill Command Controller

This block is the slave-side command layer of a single-wire serial EEPROM. A bit-level front end, which is not part of this block, delivers decoded bytes. Each byte arrives with a flag that says whether the master acknowledged it (MAK) or did not (NoMAK). After a standby pulse, the controller expects a start header and then the device address. It then decodes one command byte.

Two commands set or clear a write-enable latch. Two bulk commands fill the whole array with one constant: erase-all writes 0x00 and set-all writes 0xFF. A bulk command starts only when three conditions hold: a NoMAK closes the command byte, the latch is set, and both protect inputs are zero. In every other case the command is dropped silently. The controller returns to idle and does not request a slave acknowledge (SAK).

An accepted bulk command starts a fill cycle. The cycle writes every address in order, one per clock, through a simple write port. The controller reports busy for the whole cycle and ignores all bus activity until the cycle ends.

Top module: `eeprom_fill_ctrl`

## Requirements
- R1: While rst_ni is low and right after it is released, sak_req_o, mem_we_o and busy_o are 0, the controller is idle and the write-enable latch is clear.
- R2: A cycle with standby_i high arms the controller. A header byte of 0x55 must follow, then an address byte of 0xA0 (0xA1 when ADDR_LSB_ONE is 1). After a matching address byte, sak_req_o is 1 for one cycle, in the cycle after that byte. Any mismatch returns the controller to idle with no SAK, and it stays idle until the next standby pulse.
- R3: Command byte 0x96 sets the write-enable latch and command byte 0x91 clears it. Each of these requests SAK in the cycle after the byte.
- R4: Command 0x6D fills with 0x00 and command 0x67 fills with 0xFF. An accepted fill requests SAK and asserts mem_we_o from the cycle after the command byte. It writes addresses 0 to DEPTH-1 in ascending order, one per cycle, with constant data.
- R5: A bulk command byte that arrives with mak_i=1 (MAK) is dropped: no SAK and no writes.
- R6: A bulk command is dropped (no SAK, no writes) unless the write-enable latch is set.
- R7: A bulk command is dropped (no SAK, no writes) when bp_i is not 2'b00.
- R8: The write-enable latch clears when a fill cycle ends and when a bulk command is dropped.
- R9: busy_o is 1 exactly during the DEPTH write cycles. While it is 1, standby_i and bytes are ignored: no SAK is requested, and the controller is idle afterwards.
- R10: An unknown command byte returns the controller to idle with no SAK and leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Standby pulse detected; arms a new transaction |
| byte_valid_i | input | 1 | A decoded byte is present this cycle |
| byte_i | input | 8 | Decoded byte value |
| mak_i | input | 1 | 1 = master acknowledged the byte (MAK), 0 = NoMAK |
| bp_i | input | 2 | Block-protect setting, static |
| sak_req_o | output | 1 | Request to send slave acknowledge |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | $clog2(DEPTH) | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| busy_o | output | 1 | Internal fill cycle in progress |

## Verification
The bench targets the reasons a bulk command can be refused: a MAK after the command, a clear latch, and each nonzero protect setting. A design that skipped any one of these gates would request SAK and overwrite the array. It also checks that the latch clears after a completed fill and after a refusal. A design that kept the latch set would accept a second bulk command without a fresh enable. Other cases cover header and address mismatches, an unknown command, and bytes sent during a fill. Getting these wrong shows up as a stray SAK, a restarted or shortened address sweep, or a missing exact DEPTH count of writes ending at the last address.

// File: rtl/fill_pkg.sv
package fill_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_ADDR, ST_CMD} cmd_state_e;

  localparam logic [7:0] HDR_BYTE  = 8'h55;
  localparam logic [7:0] ADDR_BASE = 8'hA0;
  localparam logic [7:0] OP_ERASE  = 8'h6D;
  localparam logic [7:0] OP_SETALL = 8'h67;
  localparam logic [7:0] OP_WREN   = 8'h96;
  localparam logic [7:0] OP_WRDI   = 8'h91;
endpackage

// File: rtl/fill_cmd_fsm.sv
module fill_cmd_fsm
  import fill_pkg::*;
#(
  parameter bit ADDR_LSB_ONE = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       standby_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       mak_i,
  input  logic [1:0] bp_i,
  input  logic       busy_i,
  input  logic       fill_done_i,
  output logic       sak_o,
  output logic       start_o,
  output logic [7:0] pattern_o
);
  localparam logic [7:0] ADDR_BYTE = ADDR_BASE | {7'd0, ADDR_LSB_ONE};

  cmd_state_e state_q;
  logic       wel_q;
  logic       sak_q;
  logic       is_bulk;
  logic       bulk_ok;

  always_comb begin
    is_bulk   = (byte_i == OP_ERASE) || (byte_i == OP_SETALL);
    bulk_ok   = is_bulk && !mak_i && wel_q && (bp_i == 2'b00);
    start_o   = !busy_i && !standby_i && byte_valid_i && (state_q == ST_CMD) && bulk_ok;
    pattern_o = (byte_i == OP_SETALL) ? 8'hFF : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wel_q   <= 1'b0;
      sak_q   <= 1'b0;
    end else begin
      sak_q <= 1'b0;
      if (busy_i) begin
        if (fill_done_i) wel_q <= 1'b0;
      end else if (standby_i) begin
        state_q <= ST_HDR;
      end else if (byte_valid_i) begin
        case (state_q)
          ST_HDR:  state_q <= (byte_i == HDR_BYTE) ? ST_ADDR : ST_IDLE;
          ST_ADDR: begin
            if (byte_i == ADDR_BYTE) begin
              state_q <= ST_CMD;
              sak_q   <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_CMD: begin
            state_q <= ST_IDLE;
            if (is_bulk) begin
              sak_q <= bulk_ok;
              if (!bulk_ok) wel_q <= 1'b0;  // refused bulk drops the enable
            end else if (byte_i == OP_WREN) begin
              wel_q <= 1'b1;
              sak_q <= 1'b1;
            end else if (byte_i == OP_WRDI) begin
              wel_q <= 1'b0;
              sak_q <= 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sak_o = sak_q;
endmodule

// File: rtl/fill_engine.sv
module fill_engine #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    pattern_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          active_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      addr_q   <= '0;
      data_q   <= pattern_i;
    end else if (active_q) begin
      if (addr_q == LAST) active_q <= 1'b0;
      else                addr_q   <= addr_q + 1'b1;
    end
  end

  assign we_o   = active_q;
  assign busy_o = active_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
  assign done_o = active_q && (addr_q == LAST);
endmodule

// File: rtl/eeprom_fill_ctrl.sv
module eeprom_fill_ctrl #(
  parameter int    DEPTH        = 32,
  parameter bit    ADDR_LSB_ONE = 1'b0,
  localparam int   AW           = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          standby_i,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_i,
  input  logic          mak_i,
  input  logic [1:0]    bp_i,
  output logic          sak_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  output logic          busy_o
);
  logic       start;
  logic       busy;
  logic       done;
  logic [7:0] pattern;

  fill_cmd_fsm #(.ADDR_LSB_ONE(ADDR_LSB_ONE)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .standby_i   (standby_i),
    .byte_valid_i(byte_valid_i),
    .byte_i      (byte_i),
    .mak_i       (mak_i),
    .bp_i        (bp_i),
    .busy_i      (busy),
    .fill_done_i (done),
    .sak_o       (sak_req_o),
    .start_o     (start),
    .pattern_o   (pattern)
  );

  fill_engine #(.DEPTH(DEPTH), .AW(AW)) u_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .pattern_i(pattern),
    .we_o     (mem_we_o),
    .addr_o   (mem_addr_o),
    .data_o   (mem_wdata_o),
    .busy_o   (busy),
    .done_o   (done)
  );

  assign busy_o = busy;
endmodule

// File: rtl/fill_ctrl_checker.sv
module fill_ctrl_checker #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          byte_valid_i,
  input logic          mak_i,
  input logic [1:0]    bp_i,
  input logic          sak_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [7:0]    mem_wdata_o,
  input logic          busy_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assert_sak_after_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sak_req_o |-> $past(byte_valid_i));

  assert_start_addr_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> mem_addr_o == '0);

  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> mem_addr_o == AW'($past(mem_addr_o) + 1'b1));

  assert_end_last_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(mem_addr_o) == LAST);

  assert_data_const_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(mem_wdata_o));

  assert_data_value_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (mem_wdata_o == 8'h00) || (mem_wdata_o == 8'hFF));

  assert_nomak_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(byte_valid_i && !mak_i));

  assert_protect_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(bp_i) == 2'b00);

  assert_no_sak_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> !sak_req_o);
endmodule

bind eeprom_fill_ctrl fill_ctrl_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .byte_valid_i(byte_valid_i),
  .mak_i       (mak_i),
  .bp_i        (bp_i),
  .sak_req_o   (sak_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .busy_o      (busy_o)
);

// File: tb/eeprom_fill_ctrl_test.sv
`timescale 1ns/1ps
module eeprom_fill_ctrl_test;
  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [7:0] ADDR_OK = 8'hA0;

  // {exp_fill, exp_sak, wren_first, bp[1:0], mak, cmd[7:0]}
  localparam int NV = 8;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 8'h6D},
    {1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 8'h67},
    {1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'h67},
    {1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 8'h6D},
    {1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 8'h6D},
    {1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 8'h67},
    {1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 8'h6D},
    {1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'h6D}
  };
  localparam string VTAG [NV] = '{"R4", "R4", "R8", "R5", "R7", "R7", "R7", "R8"};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          standby = 1'b0;
  logic          byte_valid = 1'b0;
  logic [7:0]    bdat = 8'h00;
  logic          mak = 1'b0;
  logic [1:0]    bp = 2'b00;
  logic          sak_req_o;
  logic          mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_wdata_o;
  logic          busy_o;

  int   n_chk = 0;
  int   n_fail = 0;
  int   we_seen = 0;
  int   busy_seen = 0;
  bit   seq_err = 1'b0;
  logic [7:0] last_data = 8'h00;

  always #2 clk = ~clk;

  eeprom_fill_ctrl #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .byte_valid_i(byte_valid),
    .byte_i(bdat), .mak_i(mak), .bp_i(bp), .sak_req_o(sak_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .busy_o(busy_o)
  );

  always @(negedge clk) begin
    if (mem_we_o) begin
      if (int'(mem_addr_o) != we_seen) seq_err = 1'b1;
      if (we_seen > 0 && mem_wdata_o != last_data) seq_err = 1'b1;
      last_data = mem_wdata_o;
      we_seen++;
    end
    if (busy_o) busy_seen++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    we_seen = 0; busy_seen = 0; seq_err = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic m, output logic s);
    @(negedge clk);
    byte_valid = 1'b1; bdat = b; mak = m;
    @(negedge clk);
    byte_valid = 1'b0;
    #1 s = sak_req_o;
  endtask

  task automatic pulse_standby();
    @(negedge clk); standby = 1'b1;
    @(negedge clk); standby = 1'b0;
  endtask

  task automatic open_txn(output logic s_addr);
    logic s;
    pulse_standby();
    send_byte(8'h55, 1'b1, s);
    send_byte(ADDR_OK, 1'b1, s_addr);
  endtask

  task automatic run_cmd(input logic [7:0] c, input logic m, output logic s);
    logic sa;
    open_txn(sa);
    chk(sa == 1'b1, "R2", int'(sa), 1);
    clr_mon();
    send_byte(c, m, s);
    repeat (DEPTH + 4) @(negedge clk);
  endtask

  task automatic check_fill(input bit exp, input logic [7:0] pat, input string tag);
    chk(we_seen == (exp ? DEPTH : 0), tag, we_seen, exp ? DEPTH : 0);
    if (exp) begin
      chk(!seq_err, tag, int'(seq_err), 0);
      chk(last_data == pat, tag, int'(last_data), int'(pat));
      chk(busy_seen == DEPTH, "R9", busy_seen, DEPTH);
    end
  endtask

  initial begin
    logic s;
    logic s2;
    repeat (3) @(negedge clk);
    chk(!sak_req_o && !mem_we_o && !busy_o, "R1", int'({sak_req_o, mem_we_o, busy_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sak_req_o && !mem_we_o && !busy_o, "R1", int'({sak_req_o, mem_we_o, busy_o}), 0);
    // latch clear after reset: bulk command is refused
    run_cmd(8'h6D, 1'b0, s);
    chk(s == 1'b0, "R1", int'(s), 0);
    check_fill(1'b0, 8'h00, "R1");

    for (int i = 0; i < NV; i++) begin
      bp = VEC[i][10:9];
      if (VEC[i][11]) begin
        run_cmd(8'h96, 1'b0, s);
        chk(s == 1'b1, "R3", int'(s), 1);
      end
      run_cmd(VEC[i][7:0], VEC[i][8], s);
      chk(s == VEC[i][12], VTAG[i], int'(s), int'(VEC[i][12]));
      check_fill(VEC[i][13], (VEC[i][7:0] == 8'h67) ? 8'hFF : 8'h00, VTAG[i]);
    end
    bp = 2'b00;

    // R6: no enable at all after a refusal cleared it
    run_cmd(8'h67, 1'b0, s);
    chk(s == 1'b0, "R6", int'(s), 0);
    check_fill(1'b0, 8'hFF, "R6");

    // R2: header mismatch, then idle until standby
    pulse_standby();
    send_byte(8'h54, 1'b1, s);
    send_byte(ADDR_OK, 1'b1, s);
    chk(s == 1'b0, "R2", int'(s), 0);
    send_byte(8'h55, 1'b1, s);
    send_byte(ADDR_OK, 1'b1, s);
    chk(s == 1'b0, "R2", int'(s), 0);
    // R2: address mismatch, following command ignored
    pulse_standby();
    send_byte(8'h55, 1'b1, s);
    send_byte(8'hA2, 1'b1, s);
    chk(s == 1'b0, "R2", int'(s), 0);
    send_byte(8'h96, 1'b0, s);
    chk(s == 1'b0, "R2", int'(s), 0);

    // R3: disable after enable blocks a fill
    run_cmd(8'h96, 1'b0, s);
    run_cmd(8'h91, 1'b0, s);
    chk(s == 1'b1, "R3", int'(s), 1);
    run_cmd(8'h6D, 1'b0, s);
    chk(s == 1'b0, "R3", int'(s), 0);
    check_fill(1'b0, 8'h00, "R3");

    // R10: unknown opcode leaves latch set
    run_cmd(8'h96, 1'b0, s);
    run_cmd(8'h33, 1'b0, s);
    chk(s == 1'b0, "R10", int'(s), 0);
    chk(we_seen == 0, "R10", we_seen, 0);
    run_cmd(8'h67, 1'b0, s);
    chk(s == 1'b1, "R10", int'(s), 1);
    check_fill(1'b1, 8'hFF, "R10");

    // R9: traffic during a fill is ignored
    run_cmd(8'h96, 1'b0, s);
    open_txn(s);
    clr_mon();
    send_byte(8'h6D, 1'b0, s);
    chk(s == 1'b1 && busy_o, "R4", int'({s, busy_o}), 3);
    pulse_standby();
    send_byte(8'h55, 1'b1, s2);
    send_byte(ADDR_OK, 1'b1, s2);
    chk(s2 == 1'b0, "R9", int'(s2), 0);
    repeat (DEPTH) @(negedge clk);
    check_fill(1'b1, 8'h00, "R9");
    send_byte(8'h55, 1'b1, s2);
    send_byte(ADDR_OK, 1'b1, s2);
    chk(s2 == 1'b0, "R9", int'(s2), 0);
    // R8: latch cleared by completed fill
    run_cmd(8'h6D, 1'b0, s);
    chk(s == 1'b0, "R8", int'(s), 0);
    check_fill(1'b0, 8'h00, "R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule